// File: doc/BRIEF.md
# Preemptive Two-Master Local Bus Arbiter

This block shares one Wishbone-style slave port between two masters. The bridge master has high priority and takes the bus the moment it raises its request. The local master is the ordinary owner. The arbiter never waits for the local master to finish a sequence of accesses. If a local access is on the bus when the bridge asks, that access gets a short, bounded drain window to be acknowledged. When the window runs out, the local cycle is cut off at the slave and a sticky abort flag is raised.

The block combines the ownership logic with a bus multiplexer. Address, write data, byte selects, cycle, strobe and write-enable of the current owner are forwarded to the slave. Acknowledge and read data go back only to the owner, and only while that owner's strobe is high. A late acknowledge from a cut-off local access therefore never reaches the bridge master, which is still in its setup phase. A two-bit status output shows who owns the bus.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While and right after reset, neither grant is high, arbState is 0, abortFlag is 0, and sCyc, sStb and sWe are low.
- R2: lmGnt is never high in a cycle in which hpReq is high, and hpGnt and lmGnt are never both high.
- R3: If hpReq is sampled high while the bus is unowned, or while the local master owns it with no access in flight (lmCyc and lmStb not both high, or sAck high), the bridge owns the bus and hpGnt is high after that clock edge.
- R4: If hpReq is sampled high while the local master owns the bus with an access in flight and sAck low, the arbiter enters the drain state. The local signals keep driving the slave. A sAck during the drain hands the bus to the bridge at the next edge, and abortFlag stays 0.
- R5: The drain lasts at most DRAIN_CYC clocks. If the local access is still in flight and unacknowledged in the last drain cycle, the bridge owns the bus from the next edge. From then on the local cycle and strobe no longer reach the slave, and abortFlag is 1.
- R6: abortFlag stays 1 until a clock edge at which abortClr is high. If an abort and abortClr fall on the same edge, the flag ends up 1.
- R7: hpAck = sAck only while the bridge owns the bus and hpStb is high. lmAck = sAck only while the local master owns or drains and lmStb is high. Otherwise each acknowledge is 0. Each master's read data equals sDatR while it owns or drains the bus, and is zero otherwise.
- R8: If hpReq is sampled low while the bridge owns the bus, then after that edge the local master owns the bus (lmGnt high) if lmReq is high, and nobody owns it otherwise.
- R9: The slave address, write data, selects, sCyc, sStb and sWe equal the bridge's signals while it owns the bus. They equal the local master's signals in the local-owned and drain states, and are all zero when the bus is unowned.
- R10: arbState reports ownership as 0 unowned, 1 local, 2 draining, 3 bridge.
- R11: If the local master drops its access during the drain, the bridge owns the bus after the next edge and no abort is raised. A local owner whose lmReq falls (with hpReq low) releases the bus to unowned at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| hpReq | input | 1 | Bridge (high-priority) request |
| hpAdr | input | ADDR_W | Bridge address |
| hpDatW | input | DATA_W | Bridge write data |
| hpSel | input | DATA_W/8 | Bridge byte selects |
| hpCyc | input | 1 | Bridge cycle |
| hpStb | input | 1 | Bridge strobe |
| hpWe | input | 1 | Bridge write enable |
| hpGnt | output | 1 | Bridge owns the bus |
| hpAck | output | 1 | Gated acknowledge to bridge |
| hpDatR | output | DATA_W | Gated read data to bridge |
| lmReq | input | 1 | Local master request |
| lmAdr | input | ADDR_W | Local address |
| lmDatW | input | DATA_W | Local write data |
| lmSel | input | DATA_W/8 | Local byte selects |
| lmCyc | input | 1 | Local cycle |
| lmStb | input | 1 | Local strobe |
| lmWe | input | 1 | Local write enable |
| lmGnt | output | 1 | Local master may issue accesses |
| lmAck | output | 1 | Gated acknowledge to local master |
| lmDatR | output | DATA_W | Gated read data to local master |
| sAdr | output | ADDR_W | Slave address |
| sDatW | output | DATA_W | Slave write data |
| sSel | output | DATA_W/8 | Slave byte selects |
| sCyc | output | 1 | Slave cycle |
| sStb | output | 1 | Slave strobe |
| sWe | output | 1 | Slave write enable |
| sAck | input | 1 | Slave acknowledge |
| sDatR | input | DATA_W | Slave read data |
| abortClr | input | 1 | Clears the abort flag |
| abortFlag | output | 1 | Sticky: a local access was cut off |
| arbState | output | 2 | Ownership status (see R10) |

## Verification
The bench builds the arbiter with DRAIN_CYC=4, ADDR_W=16 and DATA_W=32. With a four-clock window, a short directed sequence covers both a drain that ends on an acknowledge and a drain that runs to expiry. The random phase also reaches expiry often, including expiry in the same edge as abortClr. The 16-bit address makes mux errors on the address path visible without making the traces longer.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

  // Ownership state, also exported as the status code.
  typedef enum logic [1:0] {
    OWN_NONE   = 2'd0,
    OWN_LOCAL  = 2'd1,
    OWN_DRAIN  = 2'd2,
    OWN_BRIDGE = 2'd3
  } ownerE;

  // Strobes from control to datapath.
  typedef struct packed {
    logic toBridge;
    logic toLocal;
  } routeT;

endpackage

// File: rtl/prio_arb_ctrl.sv
module prio_arb_ctrl
  import prio_arb_pkg::*;
#(
  parameter int DRAIN_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hpReq,
  input  logic       lmReq,
  input  logic       lmCyc,
  input  logic       lmStb,
  input  logic       sAck,
  input  logic       abortClr,
  output routeT      route,
  output logic       hpGnt,
  output logic       lmGnt,
  output logic       abortFlag,
  output logic [1:0] arbState
);

  localparam int CNT_W = $clog2(DRAIN_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DRAIN_CYC - 1);

  ownerE            state, stateNx;
  logic [CNT_W-1:0] drainCnt, drainCntNx;
  logic             abortSet;
  logic             lmBusy;

  assign lmBusy = lmCyc & lmStb;

  always_comb begin
    stateNx    = state;
    drainCntNx = drainCnt;
    abortSet   = 1'b0;
    unique case (state)
      OWN_NONE: begin
        if (hpReq)      stateNx = OWN_BRIDGE;
        else if (lmReq) stateNx = OWN_LOCAL;
      end
      OWN_LOCAL: begin
        if (hpReq) begin
          if (lmBusy && !sAck) begin
            stateNx    = OWN_DRAIN;
            drainCntNx = '0;
          end else begin
            stateNx = OWN_BRIDGE;
          end
        end else if (!lmReq) begin
          stateNx = OWN_NONE;
        end
      end
      OWN_DRAIN: begin
        if (!lmBusy || sAck) begin
          stateNx = OWN_BRIDGE;
        end else if (drainCnt == LAST_CNT) begin
          stateNx  = OWN_BRIDGE;
          abortSet = 1'b1;
        end else begin
          drainCntNx = drainCnt + 1'b1;
        end
      end
      OWN_BRIDGE: begin
        if (!hpReq) stateNx = lmReq ? OWN_LOCAL : OWN_NONE;
      end
      default: stateNx = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= OWN_NONE;
      drainCnt  <= '0;
      abortFlag <= 1'b0;
    end else begin
      state    <= stateNx;
      drainCnt <= drainCntNx;
      if (abortSet)      abortFlag <= 1'b1;
      else if (abortClr) abortFlag <= 1'b0;
    end
  end

  assign route.toBridge = (state == OWN_BRIDGE);
  assign route.toLocal  = (state == OWN_LOCAL) || (state == OWN_DRAIN);
  assign hpGnt          = (state == OWN_BRIDGE);
  assign lmGnt          = (state == OWN_LOCAL) && !hpReq;
  assign arbState       = state;

endmodule

// File: rtl/prio_arb_dp.sv
module prio_arb_dp
  import prio_arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = DATA_W / 8
) (
  input  routeT              route,
  input  logic [ADDR_W-1:0]  hpAdr,
  input  logic [DATA_W-1:0]  hpDatW,
  input  logic [SEL_W-1:0]   hpSel,
  input  logic               hpCyc,
  input  logic               hpStb,
  input  logic               hpWe,
  output logic               hpAck,
  output logic [DATA_W-1:0]  hpDatR,
  input  logic [ADDR_W-1:0]  lmAdr,
  input  logic [DATA_W-1:0]  lmDatW,
  input  logic [SEL_W-1:0]   lmSel,
  input  logic               lmCyc,
  input  logic               lmStb,
  input  logic               lmWe,
  output logic               lmAck,
  output logic [DATA_W-1:0]  lmDatR,
  output logic [ADDR_W-1:0]  sAdr,
  output logic [DATA_W-1:0]  sDatW,
  output logic [SEL_W-1:0]   sSel,
  output logic               sCyc,
  output logic               sStb,
  output logic               sWe,
  input  logic               sAck,
  input  logic [DATA_W-1:0]  sDatR
);

  // One packed bundle per master so a single mux covers every field.
  localparam int BUN_W = ADDR_W + DATA_W + SEL_W + 3;

  logic [BUN_W-1:0] hpBun, lmBun, sBun;

  assign hpBun = {hpAdr, hpDatW, hpSel, hpCyc, hpStb, hpWe};
  assign lmBun = {lmAdr, lmDatW, lmSel, lmCyc, lmStb, lmWe};

  always_comb begin
    if (route.toBridge)     sBun = hpBun;
    else if (route.toLocal) sBun = lmBun;
    else                    sBun = '0;
  end

  assign {sAdr, sDatW, sSel, sCyc, sStb, sWe} = sBun;

  // Return path: only the owner hears the slave, and only with its strobe up.
  assign hpAck  = route.toBridge & hpStb & sAck;
  assign lmAck  = route.toLocal & lmStb & sAck;
  assign hpDatR = route.toBridge ? sDatR : '0;
  assign lmDatR = route.toLocal ? sDatR : '0;

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import prio_arb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int DRAIN_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hpReq,
  input  logic [ADDR_W-1:0]     hpAdr,
  input  logic [DATA_W-1:0]     hpDatW,
  input  logic [DATA_W/8-1:0]   hpSel,
  input  logic                  hpCyc,
  input  logic                  hpStb,
  input  logic                  hpWe,
  output logic                  hpGnt,
  output logic                  hpAck,
  output logic [DATA_W-1:0]     hpDatR,
  input  logic                  lmReq,
  input  logic [ADDR_W-1:0]     lmAdr,
  input  logic [DATA_W-1:0]     lmDatW,
  input  logic [DATA_W/8-1:0]   lmSel,
  input  logic                  lmCyc,
  input  logic                  lmStb,
  input  logic                  lmWe,
  output logic                  lmGnt,
  output logic                  lmAck,
  output logic [DATA_W-1:0]     lmDatR,
  output logic [ADDR_W-1:0]     sAdr,
  output logic [DATA_W-1:0]     sDatW,
  output logic [DATA_W/8-1:0]   sSel,
  output logic                  sCyc,
  output logic                  sStb,
  output logic                  sWe,
  input  logic                  sAck,
  input  logic [DATA_W-1:0]     sDatR,
  input  logic                  abortClr,
  output logic                  abortFlag,
  output logic [1:0]            arbState
);

  localparam int SEL_W = DATA_W / 8;

  routeT route;

  prio_arb_ctrl #(.DRAIN_CYC(DRAIN_CYC)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hpReq     (hpReq),
    .lmReq     (lmReq),
    .lmCyc     (lmCyc),
    .lmStb     (lmStb),
    .sAck      (sAck),
    .abortClr  (abortClr),
    .route     (route),
    .hpGnt     (hpGnt),
    .lmGnt     (lmGnt),
    .abortFlag (abortFlag),
    .arbState  (arbState)
  );

  prio_arb_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) uDp (
    .route  (route),
    .hpAdr  (hpAdr),
    .hpDatW (hpDatW),
    .hpSel  (hpSel),
    .hpCyc  (hpCyc),
    .hpStb  (hpStb),
    .hpWe   (hpWe),
    .hpAck  (hpAck),
    .hpDatR (hpDatR),
    .lmAdr  (lmAdr),
    .lmDatW (lmDatW),
    .lmSel  (lmSel),
    .lmCyc  (lmCyc),
    .lmStb  (lmStb),
    .lmWe   (lmWe),
    .lmAck  (lmAck),
    .lmDatR (lmDatR),
    .sAdr   (sAdr),
    .sDatW  (sDatW),
    .sSel   (sSel),
    .sCyc   (sCyc),
    .sStb   (sStb),
    .sWe    (sWe),
    .sAck   (sAck),
    .sDatR  (sDatR)
  );

endmodule

// File: rtl/prio_arb_checker.sv
module prio_arb_checker #(
  parameter int DRAIN_CYC = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       hpReq,
  input logic       hpGnt,
  input logic       hpStb,
  input logic       hpAck,
  input logic       lmReq,
  input logic       lmGnt,
  input logic       lmCyc,
  input logic       lmStb,
  input logic       lmAck,
  input logic       sAck,
  input logic       sCyc,
  input logic       sStb,
  input logic       abortClr,
  input logic       abortFlag,
  input logic [1:0] arbState
);

  localparam int CW = $clog2(DRAIN_CYC + 2);

  // Consecutive cycles spent in the drain state.
  logic [CW-1:0] inDrain;
  always_ff @(posedge clk) begin
    if (!rstN)                inDrain <= '0;
    else if (arbState == 2'd2) inDrain <= inDrain + 1'b1;
    else                      inDrain <= '0;
  end

  assert_no_local_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    hpReq |-> !lmGnt);

  assert_exclusive_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(hpGnt && lmGnt));

  assert_drain_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (arbState == 2'd2) |-> (inDrain < CW'(DRAIN_CYC)));

  assert_abort_raised_R5: assert property (@(posedge clk) disable iff (!rstN)
    (arbState == 2'd2 && inDrain == CW'(DRAIN_CYC - 1) && lmCyc && lmStb && !sAck)
      |=> (abortFlag && hpGnt));

  assert_abort_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (abortFlag && !abortClr) |=> abortFlag);

  assert_hp_ack_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    hpAck |-> (hpGnt && sAck));

  assert_lm_ack_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    lmAck |-> (!hpGnt && sAck));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hpGnt && !hpReq && lmReq) |=> (arbState == 2'd1));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (arbState == 2'd0) |-> (!sCyc && !sStb));

endmodule

bind prio_bus_arbiter prio_arb_checker #(.DRAIN_CYC(DRAIN_CYC)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .hpReq     (hpReq),
  .hpGnt     (hpGnt),
  .hpStb     (hpStb),
  .hpAck     (hpAck),
  .lmReq     (lmReq),
  .lmGnt     (lmGnt),
  .lmCyc     (lmCyc),
  .lmStb     (lmStb),
  .lmAck     (lmAck),
  .sAck      (sAck),
  .sCyc      (sCyc),
  .sStb      (sStb),
  .abortClr  (abortClr),
  .abortFlag (abortFlag),
  .arbState  (arbState)
);

// File: tb/sim_prio_bus_arbiter.sv
module sim_prio_bus_arbiter;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = DW / 8;
  localparam int DRAIN = 4;

  logic clk = 1'b0;
  logic rstN;
  logic hpReq, hpCyc, hpStb, hpWe, lmReq, lmCyc, lmStb, lmWe, sAck, abortClr;
  logic [AW-1:0] hpAdr, lmAdr, sAdr;
  logic [DW-1:0] hpDatW, lmDatW, sDatW, sDatR, hpDatR, lmDatR;
  logic [SW-1:0] hpSel, lmSel, sSel;
  logic hpGnt, hpAck, lmGnt, lmAck, sCyc, sStb, sWe, abortFlag;
  logic [1:0] arbState;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  prio_bus_arbiter #(.ADDR_W(AW), .DATA_W(DW), .DRAIN_CYC(DRAIN)) u0 (
    .clk(clk), .rstN(rstN),
    .hpReq(hpReq), .hpAdr(hpAdr), .hpDatW(hpDatW), .hpSel(hpSel),
    .hpCyc(hpCyc), .hpStb(hpStb), .hpWe(hpWe),
    .hpGnt(hpGnt), .hpAck(hpAck), .hpDatR(hpDatR),
    .lmReq(lmReq), .lmAdr(lmAdr), .lmDatW(lmDatW), .lmSel(lmSel),
    .lmCyc(lmCyc), .lmStb(lmStb), .lmWe(lmWe),
    .lmGnt(lmGnt), .lmAck(lmAck), .lmDatR(lmDatR),
    .sAdr(sAdr), .sDatW(sDatW), .sSel(sSel), .sCyc(sCyc), .sStb(sStb), .sWe(sWe),
    .sAck(sAck), .sDatR(sDatR),
    .abortClr(abortClr), .abortFlag(abortFlag), .arbState(arbState)
  );

  // Expected ownership from the requirements (R3-R6, R8, R11).
  int refSt = 0;
  int refCnt = 0;
  bit refAb = 0;

  always @(posedge clk) begin
    int st;
    int cnt;
    bit ab;
    st = refSt; cnt = refCnt; ab = refAb;
    if (!rstN) begin
      st = 0; cnt = 0; ab = 0;
    end else begin
      if (abortClr) ab = 0;
      case (refSt)
        0: if (hpReq) st = 3; else if (lmReq) st = 1;
        1: if (hpReq) begin
             if (lmCyc && lmStb && !sAck) begin st = 2; cnt = 0; end
             else st = 3;
           end else if (!lmReq) st = 0;
        2: if (!(lmCyc && lmStb) || sAck) st = 3;
           else if (refCnt == DRAIN - 1) begin st = 3; ab = 1; end
           else cnt = refCnt + 1;
        default: if (!hpReq) st = lmReq ? 1 : 0;
      endcase
    end
    refSt <= st; refCnt <= cnt; refAb <= ab;
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expMux(int st);
    if (st == 3)           return {8'h0, hpAdr, hpDatW, hpSel, hpCyc, hpStb, hpWe};
    if (st == 1 || st == 2) return {8'h0, lmAdr, lmDatW, lmSel, lmCyc, lmStb, lmWe};
    return '0;
  endfunction

  task automatic compareAll();
    bit own;
    own = (refSt == 1 || refSt == 2);
    chk(hpGnt, refSt == 3, "R2 hpGnt");
    chk(lmGnt, refSt == 1 && !hpReq, "R2 lmGnt");
    chk(arbState, refSt, "R10 arbState");
    chk(abortFlag, refAb, "R6 abortFlag");
    chk({8'h0, sAdr, sDatW, sSel, sCyc, sStb, sWe}, expMux(refSt), "R9 slave mux");
    chk({hpAck, lmAck}, {refSt == 3 && hpStb && sAck, own && lmStb && sAck}, "R7 ack");
    chk({hpDatR, lmDatR}, {(refSt == 3) ? sDatR : 32'h0, own ? sDatR : 32'h0}, "R7 rdata");
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
    compareAll();
  endtask

  task automatic bridgeAccess(input logic [AW-1:0] a);
    hpAdr = a; hpCyc = 0; hpStb = 0; hpWe = 1;
    cyc(); chk(lmGnt, 0, "R2 setup");
    hpCyc = 1; hpStb = 1;
    cyc(); chk(lmGnt, 0, "R2 assert");
    sAck = 1; #1 chk(hpAck, 1, "R7 bridge ack");
    cyc(); chk(lmGnt, 0, "R2 wait");
    sAck = 0; hpCyc = 0; hpStb = 0; hpWe = 0;
    cyc(); chk(lmGnt, 0, "R2 hold");
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; hpReq = 0; hpCyc = 0; hpStb = 0; hpWe = 0; hpAdr = 0; hpDatW = 0; hpSel = 0;
    lmReq = 1; lmCyc = 1; lmStb = 1; lmWe = 1; lmAdr = 16'h1234; lmDatW = 0; lmSel = 0;
    sAck = 0; sDatR = 32'hCAFE_0001; abortClr = 0;

    // R1: reset state
    cyc(); cyc();
    chk({hpGnt, lmGnt, sCyc, sStb, sWe, abortFlag}, 6'b0, "R1 reset outputs");
    chk(arbState, 0, "R1 reset state");
    lmReq = 0; lmCyc = 0; lmStb = 0; lmWe = 0;
    rstN = 1;
    cyc();
    chk({hpGnt, lmGnt, sCyc, sStb}, 4'b0, "R1 after reset");

    // Preemption, in-flight access acknowledged inside the window
    lmReq = 1;
    cyc(); chk(lmGnt, 1, "R10 local owns"); chk(arbState, 1, "R10 code 1");
    lmCyc = 1; lmStb = 1; lmAdr = 16'hA5A5;
    cyc();
    hpReq = 1; #1 chk(lmGnt, 0, "R2 withheld at request");
    cyc(); chk(arbState, 2, "R4 drain entered"); chk(sStb, 1, "R4 local still on slave");
    cyc(); chk(arbState, 2, "R4 still draining");
    sAck = 1; #1 chk(lmAck, 1, "R7 local ack in drain"); chk(hpAck, 0, "R7 no bridge ack");
    cyc(); chk(arbState, 3, "R4 bridge owns after ack"); chk(abortFlag, 0, "R4 no abort");
    sAck = 0; lmCyc = 0; lmStb = 0;
    bridgeAccess(16'h00F0);
    hpReq = 0;
    cyc(); chk(lmGnt, 1, "R8 local restored"); chk(arbState, 1, "R8 state");

    // Preemption with late acknowledge -> abort
    lmCyc = 1; lmStb = 1;
    cyc();
    hpReq = 1;
    cyc(); chk(arbState, 2, "R5 drain start");
    for (int i = 1; i < DRAIN; i++) begin
      cyc(); chk(arbState, 2, "R5 inside window");
    end
    cyc(); chk(arbState, 3, "R5 bridge after expiry"); chk(abortFlag, 1, "R5 abort set");
    chk({sCyc, sStb}, 2'b00, "R5 local cut from slave");
    sAck = 1; #1 chk(hpAck, 0, "R7 late ack blocked"); chk(lmAck, 0, "R7 late ack to local");
    cyc(); sAck = 0;
    cyc(); chk(abortFlag, 1, "R6 sticky");
    abortClr = 1;
    cyc(); abortClr = 0; chk(abortFlag, 0, "R6 cleared");
    lmCyc = 0; lmStb = 0;

    // Back-to-back bridge accesses with local waiting
    bridgeAccess(16'h0010);
    bridgeAccess(16'h0014);
    hpReq = 0; lmReq = 0;
    cyc(); chk(arbState, 0, "R8 unowned after release");
    hpReq = 1;
    cyc(); chk(hpGnt, 1, "R3 bridge from idle");
    hpReq = 0; lmReq = 1;
    cyc();
    cyc(); chk(arbState, 1, "R10 local again");
    hpReq = 1;
    cyc(); chk(arbState, 3, "R3 bridge from idle local");

    // Local drops access during drain; local release
    hpReq = 0;
    cyc(); lmCyc = 1; lmStb = 1;
    cyc(); hpReq = 1;
    cyc(); chk(arbState, 2, "R11 drain");
    lmCyc = 0; lmStb = 0;
    cyc(); chk(arbState, 3, "R11 handover"); chk(abortFlag, 0, "R11 no abort");
    hpReq = 0;
    cyc(); lmReq = 0;
    cyc(); chk(arbState, 0, "R11 local release");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) hpReq = ~hpReq;
      if ($urandom_range(5) == 0) lmReq = ~lmReq;
      lmCyc = ($urandom_range(2) != 0); lmStb = lmCyc & ($urandom_range(3) != 0);
      lmWe = 1'($urandom); lmAdr = AW'($urandom); lmDatW = $urandom; lmSel = SW'($urandom);
      hpCyc = 1'($urandom); hpStb = hpCyc & 1'($urandom); hpWe = 1'($urandom);
      hpAdr = AW'($urandom); hpDatW = $urandom; hpSel = SW'($urandom);
      sAck = ($urandom_range(4) == 0); sDatR = $urandom;
      abortClr = ($urandom_range(15) == 0);
      cyc();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule